// File: doc/BRIEF.md
# Read History Jump Detector

This block sits on a processor's per-cycle bus and keeps a sliding record of the four most recent read cycles. Each record holds the address, the data byte, and a flag that shows whether the read came at the address directly after the read before it. Write cycles and idle cycles leave the record untouched. The record is exported unchanged, so a trace logger can capture recent fetch activity.

From the same window the block looks for the bus pattern of an absolute jump. That pattern is three reads at ascending consecutive addresses: an opcode byte $4C, then the target's low byte, then its high byte. It is followed by a read at the 16-bit address those two bytes form. On a match the block pulses a hint for one cycle, with the address of the opcode read as the source and the formed address as the target. The output is a hint and not a certainty, because ordinary data reads can reproduce the same pattern.

The read count since reset is tracked by a fill state machine. It has three states. FILL_EMPTY holds no reads. FILL_PART holds one to three reads. FILL_FULL holds four. Its transitions are: EMPTY to PART on the first read; PART to PART on further reads while fewer than four are held; PART to FULL on the fourth read; FULL stays FULL on every read. Reset returns it to EMPTY. The matcher has two states. M_QUIET moves to M_FIRE in a cycle whose read completes the pattern. M_FIRE always leaves on the next edge, back to M_QUIET, or it stays in M_FIRE only if that next read also completes a pattern.

Top module: `read_jump_detect`

## Requirements
- R1: After reset, all four history valid bits are 0 and jump_hint is 0.
- R2: A read cycle (bus_valid=1 and bus_read=1) sampled at a clock edge enters history slot 0 (hist_addr[15:0], hist_data[7:0]). Slot i moves to slot i+1 and the old slot 3 is dropped, all visible right after that edge.
- R3: The sequence flag of a new slot 0 (hist_seq bit 0) is 1 exactly when the previous slot 0 was valid and the new address equals the previous address plus one modulo 65536, so $FFFF followed by $0000 counts as sequential.
- R4: Cycles with bus_valid=0, or with bus_read=0 (writes), leave the whole history, its flags and valid bits unchanged, and a write between pattern reads does not stop a jump from being detected.
- R5: After k reads since reset, hist_vld has its lowest min(k,4) bits set and the others clear (bit 0 is the newest slot).
- R6: When a read at address {H,L} follows three reads holding $4C, L and H at addresses A, A+1 and A+2, jump_hint is 1 for the one cycle after the edge that sampled the target read, with jump_src=A and jump_dst={H,L}.
- R7: No jump is reported when the low or high byte read is not at the address directly after the previous read.
- R8: No jump is reported when the fourth read's address differs from {H,L}.
- R9: Reset clears the history, so a pattern whose reads straddle a reset is not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_read | input | 1 | 1 for a read cycle, 0 for a write |
| bus_addr | input | 16 | Cycle address |
| bus_data | input | 8 | Cycle data byte |
| jump_hint | output | 1 | One-cycle pulse: probable absolute jump seen |
| jump_src | output | 16 | Address of the opcode read of the reported jump |
| jump_dst | output | 16 | Target address of the reported jump |
| hist_addr | output | 64 | Read addresses, slot i at bits [16i+15:16i], slot 0 newest |
| hist_data | output | 32 | Read data, slot i at bits [8i+7:8i] |
| hist_seq | output | 4 | Per-slot flag: read followed the one before at address plus one |
| hist_vld | output | 4 | Per-slot valid bits |

## Verification
The target read of a jump does two things in the same cycle: it enters history slot 0, and it completes the match that raises the jump report. The bench provokes this with a jump whose target byte is itself $4C and whose following reads form a second jump, so one read both closes a report and opens the next pattern. Every cycle, a scoreboard item holds the expected full history together with the expected hint, source and target. The history and the report are therefore judged against the same edge.

// File: rtl/rhj_pkg.sv
package rhj_pkg;

    // Fill progress of the read history since reset
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;

    // Matcher report state
    typedef enum logic {
        M_QUIET = 1'b0,
        M_FIRE  = 1'b1
    } match_e;

    localparam logic [7:0] ABS_JUMP_OPC = 8'h4C;

endpackage

// File: rtl/rhj_history.sv
module rhj_history
    import rhj_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_stb,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [DATA_W-1:0]              rd_data,
    output logic [DEPTH-1:0][ADDR_W-1:0]   h_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]   h_data,
    output logic [DEPTH-1:0]               h_seq,
    output logic [DEPTH-1:0]               h_vld
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST_PART = CNT_W'(DEPTH - 1);

    fill_e            fill_q, fill_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             seq_new;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= FILL_EMPTY;
            cnt_q  <= '0;
        end else begin
            fill_q <= fill_d;
            cnt_q  <= cnt_d;
        end
    end

    // next state
    always_comb begin
        fill_d = fill_q;
        cnt_d  = cnt_q;
        unique case (fill_q)
            FILL_EMPTY: if (rd_stb) begin
                fill_d = FILL_PART;
                cnt_d  = CNT_W'(1);
            end
            FILL_PART: if (rd_stb) begin
                if (cnt_q == LAST_PART) begin
                    fill_d = FILL_FULL;
                    cnt_d  = CNT_W'(DEPTH);
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FILL_FULL: begin
                fill_d = FILL_FULL;
            end
            default: begin
                fill_d = FILL_EMPTY;
                cnt_d  = '0;
            end
        endcase
    end

    // outputs of the fill machine: valid mask
    always_comb begin
        h_vld = '0;
        unique case (fill_q)
            FILL_EMPTY: h_vld = '0;
            FILL_PART: begin
                for (int i = 0; i < DEPTH; i++)
                    h_vld[i] = (CNT_W'(i) < cnt_q);
            end
            FILL_FULL:  h_vld = '1;
            default:    h_vld = '0;
        endcase
    end

    // sequential-address test, wraps naturally at the address width
    assign seq_new = h_vld[0] && (rd_addr == h_addr[0] + 1'b1);

    // newest slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_addr[0] <= '0;
            h_data[0] <= '0;
            h_seq[0]  <= 1'b0;
        end else if (rd_stb) begin
            h_addr[0] <= rd_addr;
            h_data[0] <= rd_data;
            h_seq[0]  <= seq_new;
        end
    end

    // older slots shift by one per read
    for (genvar g = 1; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                h_addr[g] <= '0;
                h_data[g] <= '0;
                h_seq[g]  <= 1'b0;
            end else if (rd_stb) begin
                h_addr[g] <= h_addr[g-1];
                h_data[g] <= h_data[g-1];
                h_seq[g]  <= h_seq[g-1];
            end
        end
    end

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(h_addr) && $stable(h_data) && $stable(h_seq) && $stable(h_vld)));

    // R2
    newest_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (h_addr[0] == $past(rd_addr) && h_data[0] == $past(rd_data)));

    // R5
    vld_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({1'b0, h_vld} + 1'b1));

    // R5
    vld_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !h_vld[DEPTH-1]) |=> ($countones(h_vld) == $countones($past(h_vld)) + 1));

endmodule

// File: rtl/rhj_match.sv
module rhj_match
    import rhj_pkg::*;
#(
    parameter int         ADDR_W = 16,
    parameter int         DATA_W = 8,
    parameter logic [7:0] OPC    = ABS_JUMP_OPC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_data,
    input  logic              op_vld,
    input  logic [DATA_W-1:0] lo_data,
    input  logic              lo_seq,
    input  logic [DATA_W-1:0] hi_data,
    input  logic              hi_seq,
    output logic              hit,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst
);

    localparam int TGT_W = 2 * DATA_W;

    match_e           st_q, st_d;
    logic [TGT_W-1:0] tgt;
    logic             pattern;
    logic [ADDR_W-1:0] src_q, dst_q;

    assign tgt = {hi_data, lo_data};

    // the incoming read closes the window: opcode, low, high already stored
    assign pattern = rd_stb && op_vld && (op_data == DATA_W'(OPC))
                     && lo_seq && hi_seq && (rd_addr == ADDR_W'(tgt));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= M_QUIET;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            st_q <= st_d;
            if (pattern) begin
                src_q <= op_addr;
                dst_q <= rd_addr;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            M_QUIET: st_d = pattern ? M_FIRE : M_QUIET;
            M_FIRE:  st_d = pattern ? M_FIRE : M_QUIET;
            default: st_d = M_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        unique case (st_q)
            M_QUIET: hit = 1'b0;
            M_FIRE:  hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    assign src = src_q;
    assign dst = dst_q;

    // R6
    hint_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(rd_stb));

    // R7
    seq_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(lo_seq && hi_seq)) |=> !hit);

endmodule

// File: rtl/read_jump_detect.sv
module read_jump_detect
    import rhj_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_read,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_data,
    output logic                     jump_hint,
    output logic [ADDR_W-1:0]        jump_src,
    output logic [ADDR_W-1:0]        jump_dst,
    output logic [DEPTH*ADDR_W-1:0]  hist_addr,
    output logic [DEPTH*DATA_W-1:0]  hist_data,
    output logic [DEPTH-1:0]         hist_seq,
    output logic [DEPTH-1:0]         hist_vld
);

    logic                         rd_stb;
    logic [DEPTH-1:0][ADDR_W-1:0] h_addr;
    logic [DEPTH-1:0][DATA_W-1:0] h_data;
    logic [DEPTH-1:0]             h_seq;
    logic [DEPTH-1:0]             h_vld;

    assign rd_stb = bus_valid && bus_read;

    rhj_history #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (bus_addr),
        .rd_data (bus_data),
        .h_addr  (h_addr),
        .h_data  (h_data),
        .h_seq   (h_seq),
        .h_vld   (h_vld)
    );

    rhj_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OPC    (ABS_JUMP_OPC)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_addr (bus_addr),
        .op_addr (h_addr[2]),
        .op_data (h_data[2]),
        .op_vld  (h_vld[2]),
        .lo_data (h_data[1]),
        .lo_seq  (h_seq[1]),
        .hi_data (h_data[0]),
        .hi_seq  (h_seq[0]),
        .hit     (jump_hint),
        .src     (jump_src),
        .dst     (jump_dst)
    );

    assign hist_addr = h_addr;
    assign hist_data = h_data;
    assign hist_seq  = h_seq;
    assign hist_vld  = h_vld;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (hist_vld == '0 && !jump_hint));

    // R6
    report_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_hint |-> (h_addr[3] == jump_src && h_data[3] == ABS_JUMP_OPC
                       && h_addr[0] == jump_dst && h_seq[1] && h_seq[2]));

    // R3
    wrap_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && h_vld[0] && h_addr[0] == '1 && bus_addr == '0) |=> h_seq[0]);

endmodule

// File: tb/read_jump_detect_test.sv
module read_jump_detect_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_read = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        jump_hint;
    logic [15:0] jump_src, jump_dst;
    logic [63:0] hist_addr;
    logic [31:0] hist_data;
    logic [3:0]  hist_seq, hist_vld;

    always #5 clk = ~clk;

    read_jump_detect uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_read(bus_read),
        .bus_addr(bus_addr), .bus_data(bus_data), .jump_hint(jump_hint),
        .jump_src(jump_src), .jump_dst(jump_dst), .hist_addr(hist_addr),
        .hist_data(hist_data), .hist_seq(hist_seq), .hist_vld(hist_vld)
    );

    typedef struct {
        int          stamp;
        logic        hint;
        logic [15:0] src, dst;
        logic [63:0] ha;
        logic [31:0] hd;
        logic [3:0]  hs, hv;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [15:0] ma [4];
    logic [7:0]  md [4];
    logic        ms [4];
    logic        mv [4];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            ma[i] = '0; md[i] = '0; ms[i] = 1'b0; mv[i] = 1'b0;
        end
    endtask

    // driver: one bus cycle, pushes the expected outcome
    task automatic drive(input bit v, input bit r, input logic [15:0] a, input logic [7:0] d, input string tag);
        item_t it;
        @(negedge clk);
        bus_valid = v; bus_read = r; bus_addr = a; bus_data = d;
        it.hint = 1'b0; it.src = '0; it.dst = '0;
        if (v && r) begin
            // R6 pattern: slot2=$4C, slots 1 and 0 sequential, read at {slot0,slot1}
            if (mv[2] && md[2] == 8'h4C && ms[1] && ms[0] && a == {md[0], md[1]}) begin
                it.hint = 1'b1; it.src = ma[2]; it.dst = a;
            end
            for (int i = 3; i > 0; i--) begin
                ma[i] = ma[i-1]; md[i] = md[i-1]; ms[i] = ms[i-1]; mv[i] = mv[i-1];
            end
            ms[0] = mv[0] && (a == 16'(ma[0] + 16'd1));
            ma[0] = a; md[0] = d; mv[0] = 1'b1;
        end
        it.stamp = cyc;
        it.ha = {ma[3], ma[2], ma[1], ma[0]};
        it.hd = {md[3], md[2], md[1], md[0]};
        it.hs = {ms[3], ms[2], ms[1], ms[0]};
        it.hv = {mv[3], mv[2], mv[1], mv[0]};
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] d, input string tag);
        drive(1'b1, 1'b1, a, d, tag);
    endtask

    task automatic drain();
        drive(1'b0, 1'b0, '0, '0, "idle");
        while (q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        drain();
        @(negedge clk);
        rst_n = 1'b0;
        bus_valid = 1'b0; bus_read = 1'b0;
        model_clear();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(hist_vld == 4'b0, "R1 vld", 64'(hist_vld), 64'h0);
        check(jump_hint == 1'b0, "R1 hint", 64'(jump_hint), 64'h0);
    endtask

    // monitor: compares each pushed item one half cycle after its edge
    always @(negedge clk) begin
        if (q.size() != 0 && q[0].stamp < cyc) begin
            item_t it;
            it = q.pop_front();
            check(jump_hint == it.hint, {"R6 hint ", it.tag}, 64'(jump_hint), 64'(it.hint));
            if (it.hint) begin
                check(jump_src == it.src, {"R6 src ", it.tag}, 64'(jump_src), 64'(it.src));
                check(jump_dst == it.dst, {"R6 dst ", it.tag}, 64'(jump_dst), 64'(it.dst));
            end
            check(hist_addr == it.ha, {"R2 addr ", it.tag}, hist_addr, it.ha);
            check(hist_data == it.hd, {"R2 data ", it.tag}, 64'(hist_data), 64'(it.hd));
            check(hist_seq == it.hs, {"R3 seq ", it.tag}, 64'(hist_seq), 64'(it.hs));
            check(hist_vld == it.hv, {"R5 vld ", it.tag}, 64'(hist_vld), 64'(it.hv));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R5 fill and R6 basic jump
        rd(16'h8000, 8'h4C, "R5_R6 op");
        rd(16'h8001, 8'h00, "R5_R6 lo");
        rd(16'h8002, 8'h90, "R5_R6 hi");
        rd(16'h9000, 8'hEA, "R6 target");

        // R4 write and idle inside the pattern are ignored
        rd(16'hA000, 8'h4C, "R4 op");
        drive(1'b1, 1'b0, 16'h1234, 8'h55, "R4 write");
        drive(1'b0, 1'b1, 16'h7777, 8'h66, "R4 idle");
        rd(16'hA001, 8'h34, "R4 lo");
        rd(16'hA002, 8'h12, "R4 hi");
        rd(16'h1234, 8'h00, "R4 target");

        // R7 address gap breaks the pattern
        rd(16'hB000, 8'h4C, "R7 op");
        rd(16'hB002, 8'h10, "R7 lo");
        rd(16'hB003, 8'h20, "R7 hi");
        rd(16'h2010, 8'h01, "R7 target");

        // R8 wrong target address
        rd(16'hC000, 8'h4C, "R8 op");
        rd(16'hC001, 8'h10, "R8 lo");
        rd(16'hC002, 8'h20, "R8 hi");
        rd(16'h2011, 8'h01, "R8 target");

        // R3 wrap, then a target that opens a second jump
        rd(16'hFFFE, 8'h4C, "R3 op");
        rd(16'hFFFF, 8'h00, "R3 lo");
        rd(16'h0000, 8'h30, "R3 hi");
        rd(16'h3000, 8'h4C, "R3_R6 target+op");
        rd(16'h3001, 8'h00, "R6 lo2");
        rd(16'h3002, 8'h40, "R6 hi2");
        rd(16'h4000, 8'hA9, "R6 target2");
        drain();

        // R9 pattern straddling a reset
        rd(16'h5000, 8'h4C, "R9 op");
        rd(16'h5001, 8'h00, "R9 lo");
        do_reset();
        rd(16'h5002, 8'h60, "R9 hi");
        rd(16'h6000, 8'h00, "R9 target");
        drain();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule